// File: doc/BRIEF.md
# Shift Unit with Status Flags

This block is the shift stage of an integer execution pipeline. A single strobe starts one operation: a logical left shift, a logical right shift or an arithmetic right shift of a destination value that is 8, 16, 32 or 64 bits wide. The shift count is 8 bits. The block returns the shifted value together with a rebuilt flags word. The carry, overflow, sign, zero, parity and auxiliary-carry bits follow fixed rules for each opcode. Every other bit of the flags word passes through untouched.

The operation is computed combinationally and captured in output registers. The result and flags are presented with a done pulse on the cycle after the strobe, and they hold their values until the next strobe. The count is reduced to the operand width before use. A reduced count of zero is a no-op: the data is returned masked to the operand width and the flags come back exactly as supplied.

Top module: `shift_flag_unit`

## Requirements
- R1: `done_o` is high for exactly the cycle after each cycle in which `start_i` is high, and `res_o`/`flags_o` carry that operation's outcome then. Without a start, `res_o` and `flags_o` keep their values. After reset all outputs are zero.
- R2: `size_i` selects the operand width W: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64 bits. Destination bits at and above W are ignored, and result bits at and above W are zero.
- R3: The effective count n is `cnt_i` AND (W-1). When n is 0, `res_o` equals the destination masked to W bits and `flags_o` equals `flags_i` bit for bit.
- R4: Opcode 0 is the left shift, which fills with zeros. Carry takes destination bit W-n, and overflow is result bit W-1 XOR the new carry.
- R5: Opcode 1 is the logical right shift, which fills with zeros. Carry takes destination bit n-1, and overflow takes destination bit W-1.
- R6: Opcode 2 is the arithmetic right shift, which fills with destination bit W-1. Carry takes destination bit n-1, and overflow is 0.
- R7: For a nonzero n, sign (flags bit 7) equals result bit W-1, and zero (flags bit 6) is 1 exactly when the W-bit result is all zeros. Carry is flags bit 0 and overflow is flags bit 11.
- R8: For a nonzero n, parity (flags bit 2) is 1 when result bits 7:0 contain an even number of ones, and auxiliary carry (flags bit 4) is 0.
- R9: Flags bits other than 0, 2, 4, 6, 7 and 11 pass from `flags_i` to `flags_o` unchanged for every opcode and count.
- R10: Opcode 3 is a pass-through. `res_o` is the destination masked to W bits and `flags_o` equals `flags_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch one operation |
| op_i | input | 2 | Opcode: 0 left, 1 logical right, 2 arithmetic right, 3 pass |
| size_i | input | 2 | Operand width select |
| dst_i | input | DATA_W (64) | Destination operand |
| cnt_i | input | CNT_W (8) | Raw shift count |
| flags_i | input | FLAG_W (32) | Incoming flags word |
| res_o | output | DATA_W (64) | Shifted result |
| flags_o | output | FLAG_W (32) | Updated flags word |
| done_o | output | 1 | Result valid strobe |

## Verification
The bench builds the unit with its defaults: a 64-bit data path, an 8-bit count and a 32-bit flags word. With these values all four operand widths can be exercised. Each width can be driven with counts just below, at and above its own width mask, so masking to zero and wrap-around to small counts are both reached from the full 8-bit count. Because the flags word is 32 bits wide, an all-ones input also shows whether any non-status bit is disturbed.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    OP_SHL  = 2'd0,
    OP_SHR  = 2'd1,
    OP_SAR  = 2'd2,
    OP_PASS = 2'd3
  } shf_op_e;

  localparam int FL_CF = 0;
  localparam int FL_PF = 2;
  localparam int FL_AF = 4;
  localparam int FL_ZF = 6;
  localparam int FL_SF = 7;
  localparam int FL_OF = 11;
endpackage

// File: rtl/shf_prep.sv
module shf_prep #(
  parameter int DATA_W    = 64,
  parameter int CNT_W     = 8,
  parameter int NUM_SIZES = 4,
  parameter int SIZE_W    = 2,
  parameter int IDX_W     = 6
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-1:0] dst_m_o,
  output logic [DATA_W-1:0] dst_sx_o,
  output logic [DATA_W-1:0] width_mask_o,
  output logic [IDX_W-1:0]  msb_idx_o,
  output logic [IDX_W-1:0]  n_o
);
  logic [DATA_W-1:0] mask_tbl [NUM_SIZES];
  logic [IDX_W-1:0]  msb_tbl  [NUM_SIZES];
  logic [SIZE_W-1:0] sel_idx;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    assign mask_tbl[g] = (DATA_W'(1) << (8 << g)) - DATA_W'(1);
    assign msb_tbl[g]  = IDX_W'((8 << g) - 1);
  end

  // widths beyond DATA_W clamp to the widest supported size
  assign sel_idx = (int'(size_i) >= NUM_SIZES) ? SIZE_W'(NUM_SIZES - 1) : size_i;

  assign width_mask_o = mask_tbl[sel_idx];
  assign msb_idx_o    = msb_tbl[sel_idx];
  assign dst_m_o      = dst_i & width_mask_o;
  assign dst_sx_o     = dst_m_o | (dst_m_o[msb_idx_o] ? ~width_mask_o : '0);
  assign n_o          = IDX_W'(cnt_i) & msb_idx_o;
endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 6
) (
  input  shf_op_e           op_i,
  input  logic [DATA_W-1:0] dst_m_i,
  input  logic [DATA_W-1:0] dst_sx_i,
  input  logic [DATA_W-1:0] width_mask_i,
  input  logic [IDX_W-1:0]  msb_idx_i,
  input  logic [IDX_W-1:0]  n_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cf_o,
  output logic              of_o
);
  logic [IDX_W-1:0] left_out_idx;
  logic [IDX_W-1:0] right_out_idx;

  // last bit shifted out; only meaningful for n != 0
  assign left_out_idx  = msb_idx_i - n_i + IDX_W'(1);
  assign right_out_idx = n_i - IDX_W'(1);

  always_comb begin
    res_o = dst_m_i;
    cf_o  = 1'b0;
    of_o  = 1'b0;
    unique case (op_i)
      OP_SHL: begin
        res_o = (dst_m_i << n_i) & width_mask_i;
        cf_o  = dst_m_i[left_out_idx];
        of_o  = res_o[msb_idx_i] ^ cf_o;
      end
      OP_SHR: begin
        res_o = dst_m_i >> n_i;
        cf_o  = dst_m_i[right_out_idx];
        of_o  = dst_m_i[msb_idx_i];
      end
      OP_SAR: begin
        res_o = DATA_W'($signed(dst_sx_i) >>> n_i) & width_mask_i;
        cf_o  = dst_m_i[right_out_idx];
        of_o  = 1'b0;
      end
      default: begin
        res_o = dst_m_i;
      end
    endcase
  end
endmodule

// File: rtl/shf_flags.sv
module shf_flags
  import shf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int FLAG_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [IDX_W-1:0]  msb_idx_i,
  input  logic              cf_i,
  input  logic              of_i,
  input  logic              update_i,
  output logic [FLAG_W-1:0] flags_o
);
  always_comb begin
    flags_o = flags_i;
    if (update_i) begin
      flags_o[FL_CF] = cf_i;
      flags_o[FL_PF] = ~^res_i[7:0];
      flags_o[FL_AF] = 1'b0;
      flags_o[FL_ZF] = (res_i == '0);
      flags_o[FL_SF] = res_i[msb_idx_i];
      flags_o[FL_OF] = of_i;
    end
  end
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8,
  parameter int FLAG_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              done_o
);
  localparam int IDX_W     = $clog2(DATA_W);
  localparam int NUM_SIZES = $clog2(DATA_W / 8) + 1;
  localparam int SIZE_W    = 2;

  logic [DATA_W-1:0] dst_m, dst_sx, width_mask, shf_res;
  logic [IDX_W-1:0]  msb_idx, n_eff;
  logic [FLAG_W-1:0] flags_nx;
  logic              shf_cf, shf_of, update;
  shf_op_e           op;

  assign op     = shf_op_e'(op_i);
  assign update = (n_eff != '0) && (op != OP_PASS);

  shf_prep #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_SIZES(NUM_SIZES),
    .SIZE_W(SIZE_W), .IDX_W(IDX_W)
  ) u_prep (
    .dst_i       (dst_i),
    .cnt_i       (cnt_i),
    .size_i      (size_i),
    .dst_m_o     (dst_m),
    .dst_sx_o    (dst_sx),
    .width_mask_o(width_mask),
    .msb_idx_o   (msb_idx),
    .n_o         (n_eff)
  );

  shf_core #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_core (
    .op_i        (op),
    .dst_m_i     (dst_m),
    .dst_sx_i    (dst_sx),
    .width_mask_i(width_mask),
    .msb_idx_i   (msb_idx),
    .n_i         (n_eff),
    .res_o       (shf_res),
    .cf_o        (shf_cf),
    .of_o        (shf_of)
  );

  shf_flags #(.DATA_W(DATA_W), .FLAG_W(FLAG_W), .IDX_W(IDX_W)) u_flags (
    .flags_i  (flags_i),
    .res_i    (shf_res),
    .msb_idx_i(msb_idx),
    .cf_i     (shf_cf),
    .of_i     (shf_of),
    .update_i (update),
    .flags_o  (flags_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      flags_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        res_o   <= shf_res;
        flags_o <= flags_nx;
      end
    end
  end
endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8,
  parameter int FLAG_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [1:0]        op_i,
  input logic [1:0]        size_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic [DATA_W-1:0] res_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic              done_o
);
  localparam logic [FLAG_W-1:0] STATUS_MASK = FLAG_W'(12'h8D5);

  logic [DATA_W-1:0] cur_mask;
  logic              cur_nz;
  int                chk_w;

  always_comb begin
    chk_w = 8 << size_i;
    if (chk_w > DATA_W) chk_w = DATA_W;
    for (int i = 0; i < DATA_W; i++) cur_mask[i] = (i < chk_w);
    cur_nz = ((int'(cnt_i) & (chk_w - 1)) != 0) && (op_i != 2'd3);
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o); // R1
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o); // R1
  AST_HOLD_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(res_o) && $stable(flags_o))); // R1
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ((res_o & ~$past(cur_mask)) == '0)); // R2
  AST_ZERO_COUNT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !cur_nz) |=> (flags_o == $past(flags_i))); // R3
  AST_SAR_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cur_nz && op_i == 2'd2) |=> !flags_o[11]); // R6
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cur_nz) |=> (flags_o[6] == (res_o == '0))); // R7
  AST_PARITY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cur_nz) |=> (flags_o[2] == ~^res_o[7:0])); // R8
  AST_AUX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cur_nz) |=> !flags_o[4]); // R8
  AST_NONSTATUS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (((flags_o ^ $past(flags_i)) & ~STATUS_MASK) == '0)); // R9
endmodule

bind shift_flag_unit shf_unit_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .FLAG_W(FLAG_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .op_i   (op_i),
  .size_i (size_i),
  .cnt_i  (cnt_i),
  .flags_i(flags_i),
  .res_o  (res_o),
  .flags_o(flags_o),
  .done_o (done_o)
);

// File: tb/shift_flag_unit_tb.sv
module shift_flag_unit_tb;
  localparam int DW = 64;
  localparam int CW = 8;
  localparam int FW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    op_i = '0;
  logic [1:0]    size_i = '0;
  logic [DW-1:0] dst_i = '0;
  logic [CW-1:0] cnt_i = '0;
  logic [FW-1:0] flags_i = '0;
  logic [DW-1:0] res_o;
  logic [FW-1:0] flags_o;
  logic          done_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  shift_flag_unit #(.DATA_W(DW), .CNT_W(CW), .FLAG_W(FW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .size_i(size_i), .dst_i(dst_i), .cnt_i(cnt_i), .flags_i(flags_i),
    .res_o(res_o), .flags_o(flags_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected values straight from the requirements
  function automatic void model(input logic [1:0] op, input logic [1:0] size,
                                input logic [DW-1:0] dst, input logic [CW-1:0] cnt,
                                input logic [FW-1:0] fin,
                                output logic [DW-1:0] r, output logic [FW-1:0] f);
    int w, n;
    logic [DW-1:0] d;
    logic cf, ov;
    w = 8 << size;
    d = '0;
    for (int i = 0; i < w; i++) d[i] = dst[i];
    n = int'(cnt) % w;
    r = d;
    f = fin;
    if (n == 0 || op == 2'd3) return;
    r = '0;
    cf = 1'b0;
    ov = 1'b0;
    for (int i = 0; i < w; i++) begin
      case (op)
        2'd0: r[i] = (i >= n) ? d[i-n] : 1'b0;
        2'd1: r[i] = (i + n < w) ? d[i+n] : 1'b0;
        default: r[i] = (i + n < w) ? d[i+n] : d[w-1];
      endcase
    end
    case (op)
      2'd0: begin cf = d[w-n]; ov = r[w-1] ^ cf; end
      2'd1: begin cf = d[n-1]; ov = d[w-1]; end
      default: begin cf = d[n-1]; ov = 1'b0; end
    endcase
    f[0]  = cf;
    f[2]  = ~^r[7:0];
    f[4]  = 1'b0;
    f[6]  = (r == '0);
    f[7]  = r[w-1];
    f[11] = ov;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [1:0] size,
                        input logic [DW-1:0] dst, input logic [CW-1:0] cnt,
                        input logic [FW-1:0] fin, input string tag);
    logic [DW-1:0] er;
    logic [FW-1:0] ef;
    model(op, size, dst, cnt, fin, er, ef);
    @(negedge clk);
    op_i = op; size_i = size; dst_i = dst; cnt_i = cnt; flags_i = fin;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o === 1'b1, {tag, " done"}, DW'(done_o), DW'(1));
    check(res_o === er, {tag, " result"}, res_o, er);
    check(flags_o === ef, {tag, " flags"}, DW'(flags_o), DW'(ef));
  endtask

  task automatic test_reset();
    check(res_o === '0, "R1 reset result", res_o, '0);
    check(flags_o === '0, "R1 reset flags", DW'(flags_o), '0);
    check(done_o === 1'b0, "R1 reset done", DW'(done_o), '0);
  endtask

  task automatic test_left();
    run_op(2'd0, 2'd0, 64'h81, 8'd1, 32'h0, "R4 shl8 n1");
    run_op(2'd0, 2'd0, 64'h40, 8'd1, 32'h0, "R4 shl8 ovf");
    run_op(2'd0, 2'd1, 64'hF00F, 8'd4, 32'h8D5, "R4 shl16 n4");
    run_op(2'd0, 2'd2, 64'h1234_5678, 8'd31, 32'h0, "R4 shl32 n31");
    run_op(2'd0, 2'd3, 64'h8000_0000_0000_0001, 8'd63, 32'h0, "R4 shl64 n63");
  endtask

  task automatic test_logical_right();
    run_op(2'd1, 2'd0, 64'h81, 8'd1, 32'h0, "R5 shr8 n1");
    run_op(2'd1, 2'd1, 64'h8001, 8'd15, 32'h0, "R5 shr16 n15");
    run_op(2'd1, 2'd3, 64'hFFFF_0000_0000_0000, 8'd48, 32'h0, "R5 shr64 n48");
  endtask

  task automatic test_arith_right();
    run_op(2'd2, 2'd0, 64'h85, 8'd2, 32'h800, "R6 sar8 neg");
    run_op(2'd2, 2'd1, 64'h4001, 8'd1, 32'h800, "R6 sar16 pos");
    run_op(2'd2, 2'd2, 64'h8000_0000, 8'd31, 32'h0, "R6 sar32 n31");
    run_op(2'd2, 2'd3, 64'h8000_0000_0000_0000, 8'd63, 32'h0, "R6 sar64 n63");
  endtask

  task automatic test_zero_count();
    run_op(2'd0, 2'd0, 64'hAB, 8'd8, 32'hFFFF_FFFF, "R3 masked8 zero");
    run_op(2'd1, 2'd3, 64'hDEAD_BEEF_0000_1111, 8'd64, 32'h0000_0A5A, "R3 masked64 zero");
    run_op(2'd2, 2'd1, 64'h8000, 8'd0, 32'h1234_5678, "R3 raw zero");
  endtask

  task automatic test_count_wrap();
    run_op(2'd0, 2'd0, 64'h01, 8'd9, 32'h0, "R3 wrap8 to1");
    run_op(2'd1, 2'd1, 64'h8000, 8'h21, 32'h0, "R3 wrap16 to1");
    run_op(2'd0, 2'd2, 64'h1, 8'hFF, 32'h0, "R3 wrap32 to31");
  endtask

  task automatic test_upper_bits();
    run_op(2'd1, 2'd0, 64'hFFFF_FFFF_FFFF_FF02, 8'd1, 32'h0, "R2 upper ignored shr8");
    run_op(2'd2, 2'd1, 64'hFFFF_FFFF_FFFF_7FFE, 8'd1, 32'h0, "R2 upper ignored sar16");
    run_op(2'd0, 2'd2, 64'hAAAA_AAAA_C000_0000, 8'd1, 32'h0, "R2 upper zero shl32");
  endtask

  task automatic test_flag_edges();
    run_op(2'd0, 2'd0, 64'h80, 8'd1, 32'h0, "R7 zero result");
    run_op(2'd1, 2'd0, 64'hE0, 8'd1, 32'h0, "R8 odd parity");
    run_op(2'd1, 2'd3, 64'h0300_0000_0000_0000, 8'd56, 32'h10, "R8 parity low byte aux clear");
    run_op(2'd2, 2'd2, 64'hFFFF_FFFF, 8'd5, 32'h0, "R7 sign set");
  endtask

  task automatic test_nonstatus();
    run_op(2'd0, 2'd3, 64'h0123_4567_89AB_CDEF, 8'd7, 32'hFFFF_FFFF, "R9 ones shl");
    run_op(2'd2, 2'd0, 64'h7F, 8'd3, 32'hFFFF_F72A, "R9 mixed sar");
  endtask

  task automatic test_pass_op();
    run_op(2'd3, 2'd1, 64'hFFFF_FFFF_FFFF_ABCD, 8'd3, 32'h0000_0ACE, "R10 pass");
    run_op(2'd3, 2'd3, 64'h8000_0000_0000_0000, 8'd1, 32'h0, "R10 pass64");
  endtask

  task automatic test_hold();
    logic [DW-1:0] r0;
    logic [FW-1:0] f0;
    run_op(2'd0, 2'd1, 64'h00F1, 8'd3, 32'h0, "R1 setup");
    r0 = res_o;
    f0 = flags_o;
    op_i = 2'd1; dst_i = '1; cnt_i = 8'd5; flags_i = '1;
    @(negedge clk);
    check(done_o === 1'b0, "R1 done one cycle", DW'(done_o), '0);
    check(res_o === r0, "R1 result held", res_o, r0);
    check(flags_o === f0, "R1 flags held", DW'(flags_o), DW'(f0));
  endtask

  task automatic test_sweep();
    logic [DW-1:0] x;
    x = 64'h9E37_79B9_7F4A_7C15;
    for (int k = 0; k < 200; k++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      run_op(x[1:0] == 2'd3 ? 2'd0 : x[1:0], x[3:2], x, x[15:8], x[63:32],
             "R4 R5 R6 R7 R8 sweep");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    test_left();
    test_logical_right();
    test_arith_right();
    test_zero_count();
    test_count_wrap();
    test_upper_bits();
    test_flag_edges();
    test_nonstatus();
    test_pass_op();
    test_hold();
    test_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule